// File: doc/BRIEF.md
# Tag-Propagating Logic Gate Evaluator

This block evaluates one two-input logic gate (AND, OR or XOR) on a pair of single-bit operands. Alongside the logic result it produces a taint mask. Each operand arrives with an N-bit tag mask, and each mask bit marks the presence of one named tag. A tag reaches the output mask only when the operand carrying it could change the gate result, given the value held by the other operand. This lets a larger tracking netlist follow where a marked signal can have an effect.

A compile-time map gives each tag index a small group number. Group 0 means the tag belongs to no group. Tags that share a nonzero group never block one another. If the other operand carries any tag of the same group, the tag passes even when the other operand's logic value would normally stop it.

The unit is purely combinational and holds no state. A reserved opcode behaves like a cell whose behaviour is not known: every tag is forwarded and the logic output is held at 0. No attempt is made to detect cancellation, so an operand combined with itself still passes its tags.

Top module: `tag_gate_eval`

## Requirements
- R1: The opcode encoding is 2'b00 = AND, 2'b01 = OR and 2'b10 = XOR. `y_val_o` is the selected gate applied to `a_val_i` and `b_val_i`.
- R2: With opcode 2'b10 (XOR), `y_tags_o` equals `a_tags_i | b_tags_i` for every operand value.
- R3: With opcode 2'b00 (AND), a tag on one operand reaches `y_tags_o` when the other operand's value is 1. When that value is 0, the tag is blocked unless R5 applies.
- R4: With opcode 2'b01 (OR), a tag on one operand reaches `y_tags_o` when the other operand's value is 0. When that value is 1, the tag is blocked unless R5 applies.
- R5: A tag whose group number is nonzero is forwarded whenever the other operand carries any tag with the same group number, whatever that operand's value. For example, with the default map, AND of (0, tag 0) and (0, tag 1) gives value 0 and tag mask 8'h03.
- R6: Sharing a group gives no rescue in two cases. A tag of group 0 is never rescued, even when the same tag sits on the other operand. A tag is not rescued by tags of a different group: AND of (0, tags 0 and 3) with (0, tag 1) gives mask 8'h03, and tag 3 is blocked.
- R7: The opcode 2'b11 drives `y_val_o` to 0 and forwards all tags of both operands.
- R8: `y_tags_o` never holds a tag that is absent from both `a_tags_i` and `b_tags_i`.
- R9: Operand cancellation is not analysed. XOR of an operand with an identical copy of itself gives value 0 and keeps that operand's full tag mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | Gate select (00 AND, 01 OR, 10 XOR, 11 reserved) |
| a_val_i | input | 1 | Logic value of operand A |
| a_tags_i | input | NUM_TAGS | Tag mask of operand A |
| b_val_i | input | 1 | Logic value of operand B |
| b_tags_i | input | NUM_TAGS | Tag mask of operand B |
| y_val_o | output | 1 | Gate result |
| y_tags_o | output | NUM_TAGS | Tag mask forwarded to the result |

## Verification
The two tag-passing paths can act on the same tag in the same evaluation. One path is value-based gating, where the other operand's logic level opens or closes the gate. The other is group rescue, where a same-group tag on the other operand forces the tag through. The bench provokes this collision by crossing every opcode and operand-value pair with tag masks that mix grouped, ungrouped and cross-group tags, and adds the directed cases where a blocking value meets a rescuing tag. Each result is judged tag by tag against a reference model that applies the two paths as separate conditions joined by OR.

// File: rtl/tag_gate_pkg.sv
// Package: shared opcode type for the tag-propagating gate evaluator.
// Assumes a 2-bit opcode; the fourth code is reserved and handled as an unknown cell.
package tag_gate_pkg;

    typedef enum logic [1:0] {
        GATE_AND  = 2'b00,
        GATE_OR   = 2'b01,
        GATE_XOR  = 2'b10,
        GATE_RSVD = 2'b11
    } gate_op_e;

endpackage

// File: rtl/tag_group_sense.sv
// Module: tag_group_sense
// For every tag index i this module reports whether the other operand holds any
// tag that shares i's group. Group 0 means "no group" and never produces a hit.
// Assumes GROUP_MAP packs one GROUP_W-bit group number per tag, with tag 0 in
// the low bits.
module tag_group_sense #(
    parameter int NUM_TAGS = 8,
    parameter int GROUP_W  = 4,
    parameter logic [NUM_TAGS*GROUP_W-1:0] GROUP_MAP = '0
) (
    input  logic [NUM_TAGS-1:0] other_tags_i,
    output logic [NUM_TAGS-1:0] grp_hit_o
);

    for (genvar gi = 0; gi < NUM_TAGS; gi++) begin : g_tag
        localparam logic [GROUP_W-1:0] MY_GRP = GROUP_MAP[gi*GROUP_W +: GROUP_W];
        logic hit;

        // Scan the other operand for a tag of the same nonzero group.
        always_comb begin
            hit = 1'b0;
            if (MY_GRP != '0) begin
                for (int j = 0; j < NUM_TAGS; j++) begin
                    if (other_tags_i[j] && (GROUP_MAP[j*GROUP_W +: GROUP_W] == MY_GRP)) begin
                        hit = 1'b1;
                    end
                end
            end
        end

        assign grp_hit_o[gi] = hit;
    end

endmodule

// File: rtl/tag_forward_mask.sv
// Module: tag_forward_mask
// Selects which tags of one operand reach the result. The gate is open when the
// other operand's value lets this operand steer the output. Closed tags can still
// pass through a same-group hit from the other operand.
// Assumes other_grp_hit_i comes from tag_group_sense fed with the other operand.
module tag_forward_mask #(
    parameter int NUM_TAGS = 8
) (
    input  logic [1:0]          op_i,
    input  logic [NUM_TAGS-1:0] own_tags_i,
    input  logic                other_val_i,
    input  logic [NUM_TAGS-1:0] other_grp_hit_i,
    output logic [NUM_TAGS-1:0] fwd_tags_o
);
    import tag_gate_pkg::*;

    gate_op_e op;
    logic     open;

    assign op = gate_op_e'(op_i);

    // Decide whether the other operand's value lets this operand affect the result.
    always_comb begin
        unique case (op)
            GATE_AND: open = other_val_i;
            GATE_OR:  open = ~other_val_i;
            GATE_XOR: open = 1'b1;
            default:  open = 1'b1;
        endcase
    end

    // Forward own tags through the open gate or through a group rescue.
    always_comb begin
        fwd_tags_o = own_tags_i & ({NUM_TAGS{open}} | other_grp_hit_i);
    end

endmodule

// File: rtl/gate_value.sv
// Module: gate_value
// Computes the plain logic result of the selected gate. The reserved opcode
// yields 0. Assumes single-bit operands.
module gate_value (
    input  logic [1:0] op_i,
    input  logic       a_i,
    input  logic       b_i,
    output logic       y_o
);
    import tag_gate_pkg::*;

    gate_op_e op;
    assign op = gate_op_e'(op_i);

    // Evaluate the selected gate.
    always_comb begin
        unique case (op)
            GATE_AND: y_o = a_i & b_i;
            GATE_OR:  y_o = a_i | b_i;
            GATE_XOR: y_o = a_i ^ b_i;
            default:  y_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tag_gate_eval.sv
// Module: tag_gate_eval (top)
// Combinational two-operand gate with per-tag taint forwarding and group-aware
// rescue. Holds no state, so it has no clock or reset. Assumes TAG_GROUP packs
// one GROUP_W-bit group number per tag, with tag 0 in the low bits.
module tag_gate_eval #(
    parameter int NUM_TAGS = 8,
    parameter int GROUP_W  = 4,
    parameter logic [NUM_TAGS*GROUP_W-1:0] TAG_GROUP = 32'h0022_0111
) (
    input  logic [1:0]          op_i,
    input  logic                a_val_i,
    input  logic [NUM_TAGS-1:0] a_tags_i,
    input  logic                b_val_i,
    input  logic [NUM_TAGS-1:0] b_tags_i,
    output logic                y_val_o,
    output logic [NUM_TAGS-1:0] y_tags_o
);

    logic [NUM_TAGS-1:0] a_rescue;   // A's tags with a same-group partner on B
    logic [NUM_TAGS-1:0] b_rescue;   // B's tags with a same-group partner on A
    logic [NUM_TAGS-1:0] a_fwd;
    logic [NUM_TAGS-1:0] b_fwd;

    tag_group_sense #(
        .NUM_TAGS(NUM_TAGS), .GROUP_W(GROUP_W), .GROUP_MAP(TAG_GROUP)
    ) u_sense_on_b (
        .other_tags_i(b_tags_i),
        .grp_hit_o   (a_rescue)
    );

    tag_group_sense #(
        .NUM_TAGS(NUM_TAGS), .GROUP_W(GROUP_W), .GROUP_MAP(TAG_GROUP)
    ) u_sense_on_a (
        .other_tags_i(a_tags_i),
        .grp_hit_o   (b_rescue)
    );

    tag_forward_mask #(.NUM_TAGS(NUM_TAGS)) u_fwd_a (
        .op_i           (op_i),
        .own_tags_i     (a_tags_i),
        .other_val_i    (b_val_i),
        .other_grp_hit_i(a_rescue),
        .fwd_tags_o     (a_fwd)
    );

    tag_forward_mask #(.NUM_TAGS(NUM_TAGS)) u_fwd_b (
        .op_i           (op_i),
        .own_tags_i     (b_tags_i),
        .other_val_i    (a_val_i),
        .other_grp_hit_i(b_rescue),
        .fwd_tags_o     (b_fwd)
    );

    gate_value u_value (
        .op_i(op_i),
        .a_i (a_val_i),
        .b_i (b_val_i),
        .y_o (y_val_o)
    );

    // Merge the forwarded tags of both operands.
    always_comb begin
        y_tags_o = a_fwd | b_fwd;
    end

endmodule

// File: rtl/tag_gate_eval_chk.sv
// Module: tag_gate_eval_chk
// Checker bound to tag_gate_eval. The block is combinational, so every check is
// an immediate assertion evaluated whenever the ports change.
module tag_gate_eval_chk #(
    parameter int NUM_TAGS = 8
) (
    input logic [1:0]          op_i,
    input logic                a_val_i,
    input logic [NUM_TAGS-1:0] a_tags_i,
    input logic                b_val_i,
    input logic [NUM_TAGS-1:0] b_tags_i,
    input logic                y_val_o,
    input logic [NUM_TAGS-1:0] y_tags_o
);

    // Check the port relations whenever any port changes.
    always_comb begin
        // R8
        tag_subset_chk: assert ((y_tags_o & ~(a_tags_i | b_tags_i)) == '0)
            else $error("output carries a tag absent from both inputs");
        // R2
        xor_all_tags_chk: assert (op_i != 2'b10 || y_tags_o == (a_tags_i | b_tags_i))
            else $error("XOR dropped a tag");
        // R3
        and_open_chk: assert (!(op_i == 2'b00 && a_val_i && b_val_i) || y_tags_o == (a_tags_i | b_tags_i))
            else $error("AND with both values 1 dropped a tag");
        // R4
        or_open_chk: assert (!(op_i == 2'b01 && !a_val_i && !b_val_i) || y_tags_o == (a_tags_i | b_tags_i))
            else $error("OR with both values 0 dropped a tag");
        // R7
        rsvd_value_chk: assert (op_i != 2'b11 || (!y_val_o && y_tags_o == (a_tags_i | b_tags_i)))
            else $error("reserved opcode misbehaved");
        // R1
        xor_value_chk: assert (op_i != 2'b10 || y_val_o == (a_val_i ^ b_val_i))
            else $error("XOR value wrong");
    end

endmodule

bind tag_gate_eval tag_gate_eval_chk #(.NUM_TAGS(NUM_TAGS)) u_chk (
    .op_i    (op_i),
    .a_val_i (a_val_i),
    .a_tags_i(a_tags_i),
    .b_val_i (b_val_i),
    .b_tags_i(b_tags_i),
    .y_val_o (y_val_o),
    .y_tags_o(y_tags_o)
);

// File: tb/tag_gate_eval_bench.sv
// Scoreboard bench for tag_gate_eval. The driver applies one vector per cycle
// just after the rising edge and queues the expected result. The monitor pops
// and compares on the falling edge.
module tag_gate_eval_bench;

    localparam int NT = 8;
    localparam int GW = 4;
    localparam logic [NT*GW-1:0] MAP = 32'h0022_0111;
    // Group number per tag, written independently of MAP's packing.
    localparam int GRP [NT] = '{1, 1, 1, 0, 2, 2, 0, 0};

    typedef struct {
        logic [1:0]    op;
        logic          av;
        logic [NT-1:0] at;
        logic          bv;
        logic [NT-1:0] bt;
        logic          ev;
        logic [NT-1:0] et;
        string         req;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0]    op = 2'b00;
    logic          av = 1'b0;
    logic          bv = 1'b0;
    logic [NT-1:0] at = '0;
    logic [NT-1:0] bt = '0;
    logic          yv;
    logic [NT-1:0] yt;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tag_gate_eval #(.NUM_TAGS(NT), .GROUP_W(GW), .TAG_GROUP(MAP)) u_tag_gate_eval (
        .op_i(op), .a_val_i(av), .a_tags_i(at), .b_val_i(bv), .b_tags_i(bt),
        .y_val_o(yv), .y_tags_o(yt)
    );

    // Reference: does the other operand hold a tag of the same nonzero group as tag i?
    function automatic bit rescued(int i, logic [NT-1:0] other);
        if (GRP[i] == 0) return 1'b0;
        for (int j = 0; j < NT; j++)
            if (other[j] && GRP[j] == GRP[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit opens(logic [1:0] o, logic other_v);
        case (o)
            2'b00:   return other_v;
            2'b01:   return !other_v;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [NT-1:0] ref_tags(logic [1:0] o, logic a_v, logic [NT-1:0] a_t,
                                                logic b_v, logic [NT-1:0] b_t);
        logic [NT-1:0] r = '0;
        for (int i = 0; i < NT; i++) begin
            if (a_t[i] && (opens(o, b_v) || rescued(i, b_t))) r[i] = 1'b1;
            if (b_t[i] && (opens(o, a_v) || rescued(i, a_t))) r[i] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic ref_val(logic [1:0] o, logic a_v, logic b_v);
        case (o)
            2'b00:   return a_v & b_v;
            2'b01:   return a_v | b_v;
            2'b10:   return a_v ^ b_v;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: apply a vector and queue its expected result (or a forced one).
    task automatic drive(logic [1:0] o, logic a_v, logic [NT-1:0] a_t, logic b_v,
                         logic [NT-1:0] b_t, string req, bit force_exp = 1'b0,
                         logic f_v = 1'b0, logic [NT-1:0] f_t = '0);
        item_t it;
        @(posedge clk);
        #1;
        op = o; av = a_v; at = a_t; bv = b_v; bt = b_t;
        it.op = o; it.av = a_v; it.at = a_t; it.bv = b_v; it.bt = b_t; it.req = req;
        it.ev = force_exp ? f_v : ref_val(o, a_v, b_v);
        it.et = force_exp ? f_t : ref_tags(o, a_v, a_t, b_v, b_t);
        q.push_back(it);
    endtask

    // Monitor: compare each queued item on the falling edge after it was applied.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(it.req, "value", 32'(yv), 32'(it.ev));
                check(it.req, "tags", 32'(yt), 32'(it.et));
                check("R8", "subset", 32'(yt & ~(it.at | it.bt)), 32'h0);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        logic [NT-1:0] masks [6] = '{8'h00, 8'h01, 8'h08, 8'h12, 8'h41, 8'hFF};
        // Reset state: all inputs idle, so the result is 0 with no tags (R1).
        repeat (2) @(negedge clk);
        check("R1", "idle value", 32'(yv), 32'h0);
        check("R1", "idle tags", 32'(yt), 32'h0);
        @(posedge clk);
        rst_n = 1'b1;

        // Sweep: opcodes x values x sampled masks.
        for (int o = 0; o < 4; o++) begin
            for (int v = 0; v < 4; v++) begin
                for (int i = 0; i < 6; i++) begin
                    for (int j = 0; j < 6; j++) begin
                        string r;
                        case (o)
                            0: r = "R3";
                            1: r = "R4";
                            2: r = "R2";
                            default: r = "R7";
                        endcase
                        drive(2'(o), v[1], masks[i], v[0], masks[j], r);
                    end
                end
            end
        end

        // Directed: same-group rescue under AND with both values 0.
        drive(2'b00, 1'b0, 8'h01, 1'b0, 8'h02, "R5", 1'b1, 1'b0, 8'h03);
        // Directed: same-group rescue under OR with both values 1.
        drive(2'b01, 1'b1, 8'h10, 1'b1, 8'h20, "R5", 1'b1, 1'b1, 8'h30);
        // Directed: the cross-group tag stays blocked.
        drive(2'b00, 1'b0, 8'h09, 1'b0, 8'h02, "R6", 1'b1, 1'b0, 8'h03);
        // Directed: an identical group-0 tag is not rescued.
        drive(2'b00, 1'b0, 8'h40, 1'b0, 8'h40, "R6", 1'b1, 1'b0, 8'h00);
        // Directed: group 1 does not rescue group 2.
        drive(2'b01, 1'b1, 8'h10, 1'b1, 8'h01, "R6", 1'b1, 1'b1, 8'h00);
        // Directed: AND with the other value 1 opens the gate.
        drive(2'b00, 1'b0, 8'h08, 1'b1, 8'h00, "R3", 1'b1, 1'b0, 8'h08);
        // Directed: OR with the other value 0 opens the gate.
        drive(2'b01, 1'b1, 8'h80, 1'b0, 8'h00, "R4", 1'b1, 1'b1, 8'h80);
        // Directed: an operand XORed with itself keeps its tags.
        drive(2'b10, 1'b1, 8'hC9, 1'b1, 8'hC9, "R9", 1'b1, 1'b0, 8'hC9);
        // Directed: the reserved opcode gives value 0 with all tags.
        drive(2'b11, 1'b1, 8'h0F, 1'b1, 8'hF0, "R7", 1'b1, 1'b0, 8'hFF);
        // Directed: gate values with no tags.
        drive(2'b00, 1'b1, 8'h00, 1'b1, 8'h00, "R1", 1'b1, 1'b1, 8'h00);
        drive(2'b01, 1'b0, 8'h00, 1'b1, 8'h00, "R1", 1'b1, 1'b1, 8'h00);
        drive(2'b10, 1'b1, 8'h00, 1'b1, 8'h00, "R1", 1'b1, 1'b0, 8'h00);

        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule